// File: doc/BRIEF.md
# Dual-Mode Sample Capture Engine

This block records a parallel bundle of probe channels into an on-chip sample store. A run is started with a one-cycle arm request. Each time a sample strobe occurs, every channel is caught in one latch together, and the latched word is then written to the next free store slot. The strobe has two sources, chosen by a mode input. In state mode it is the rising edge of an external system-clock input, which is first passed through a two-flop synchronizer. In timing mode it is an internal enable that fires once every N+1 core clocks.

A run ends when the store is full or when an abort request arrives. After that, the number of stored words is reported and any slot can be read through an address/data port with one cycle of latency. While a run is active the read port holds its last value. Three one-hot status flags show whether the block is waiting for its first sample, capturing, or finished.

Top module: `la_capture`

## Requirements
- R1: After reset, armed, capturing and done are 0, sampleCount is 0 and rdData is 0.
- R2: In state mode (modeTiming=0), each rising edge of sysClkIn stores exactly one sample, and a falling edge stores none. The channel value is taken within three core cycles after the rising edge, so a value held for at least four core cycles after the edge is the one stored.
- R3: In timing mode (modeTiming=1) with divN=N, the sample is taken from the chanIn value present at core edge k*(N+1), counted from the edge that accepts armReq. This holds for every k, including N=0.
- R4: The k-th sample of a run (k counted from 1) is stored at address k-1, and sampleCount equals the number of samples stored so far.
- R5: When DEPTH samples have been stored, done is 1 from the edge that took the last sample. sampleCount stays at DEPTH and no further samples are taken.
- R6: An abortReq during an active run sets done at the next edge. sampleCount keeps the number already stored, and the stored words stay readable.
- R7: armReq sets armed and clears done and sampleCount at the next edge, from any state. If armReq and abortReq arrive together, armReq takes priority.
- R8: armed is 1 from arm until the first sample, capturing is 1 from the first sample until the run ends, and done is 1 after the run ends. At most one of the three flags is 1 at a time.
- R9: When the block is idle or done, rdData shows the stored word at rdAddr one edge after rdAddr is applied. While armed or capturing, rdData does not change, whatever rdAddr does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chanIn | input | CH_W | Probe channel bundle |
| sysClkIn | input | 1 | Observed system clock, asynchronous to clk |
| modeTiming | input | 1 | 1 = internal divider strobe, 0 = system-clock edge strobe |
| divN | input | DIV_W | Divider setting; the internal strobe period is divN+1 core clocks |
| armReq | input | 1 | Start a new run |
| abortReq | input | 1 | End the active run early |
| rdAddr | input | AW | Readout slot address |
| rdData | output | CH_W | Stored word at rdAddr, registered |
| sampleCount | output | CNT_W | Number of words stored in the current or last run |
| armed | output | 1 | Run started, no sample taken yet |
| capturing | output | 1 | Run active, at least one sample taken |
| done | output | 1 | Run finished by a full store or by abort |

## Verification
If the write slot or the sample count goes wrong, the error shows at the ports as soon as the run ends. sampleCount or the time at which done rises will differ from the value computed from the divider setting or the edge count, and the readback at one address will differ from its index-based value. If the divider or the edge detector is off by one cycle, every timing-mode word read back is shifted, and state-mode counts gain or lose samples within one system-clock period. A read port that is not frozen shows up within one cycle of an address change during a run.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DONE  = 2'd3
  } capState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchEn;
    logic readEn;
  } capCtrl_t;

endpackage

// File: rtl/la_cap_strobe.sv
module la_cap_strobe #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sysClkIn,
  input  logic             modeTiming,
  input  logic [DIV_W-1:0] divN,
  input  logic             runActive,
  input  logic             restart,
  output logic             sampleTick
);

  logic [2:0]       syncQ;
  logic             sysEdge;
  logic [DIV_W-1:0] divCnt;
  logic             divTick;

  // two-flop synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '0;
    else        syncQ <= {syncQ[1:0], sysClkIn};
  end

  assign sysEdge = syncQ[1] & ~syncQ[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    divCnt <= '0;
    else if (restart || !runActive) divCnt <= '0;
    else if (divCnt == divN)        divCnt <= '0;
    else                            divCnt <= divCnt + DIV_W'(1);
  end

  assign divTick    = (divCnt == divN);
  assign sampleTick = runActive & (modeTiming ? divTick : sysEdge);

  // R3: with a nonzero divisor two timing ticks are never adjacent
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleTick && modeTiming && divN != '0 && $stable(divN) && $stable(modeTiming))
      |=> !sampleTick);

  // R2: one synchronized rising edge gives a single-cycle strobe
  assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleTick && !modeTiming && $stable(modeTiming)) |=> !(sampleTick && !modeTiming));

endmodule

// File: rtl/la_cap_ctrl.sv
module la_cap_ctrl
  import la_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armReq,
  input  logic             abortReq,
  input  logic             sampleTick,
  output capCtrl_t         strb,
  output logic [AW-1:0]    slot,
  output logic [CNT_W-1:0] sampleCount,
  output logic             runActive,
  output logic             armed,
  output logic             capturing,
  output logic             done
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  capState_t        state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    runActive    = (state == ST_ARMED) || (state == ST_CAPT);
    strb.latchEn = runActive & sampleTick & ~armReq & ~abortReq;
    strb.readEn  = ~runActive;
    slot         = cnt[AW-1:0];
    sampleCount  = cnt;
    armed        = (state == ST_ARMED);
    capturing    = (state == ST_CAPT);
    done         = (state == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (armReq) begin
      state <= ST_ARMED;
      cnt   <= '0;
    end else if (runActive && abortReq) begin
      state <= ST_DONE;
    end else if (strb.latchEn) begin
      cnt   <= cnt + CNT_W'(1);
      state <= (cnt == LAST_CNT) ? ST_DONE : ST_CAPT;
    end
  end

  // R7: arm restarts from any state
  assert_arm_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armReq |=> (armed && !done && !capturing && sampleCount == '0));

  // R6: abort finishes the run and keeps the count
  assert_abort_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (runActive && abortReq && !armReq) |=> (done && $stable(sampleCount)));

  // R5: the last slot ends the run
  assert_full_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.latchEn && sampleCount == LAST_CNT) |=> (done && sampleCount == FULL_CNT));

  // R4: count never exceeds the store depth
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sampleCount <= FULL_CNT);

  // R5: once finished, the count holds until a new arm
  assert_done_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !armReq) |=> (done && $stable(sampleCount)));

endmodule

// File: rtl/la_cap_path.sv
module la_cap_path
  import la_cap_pkg::*;
#(
  parameter int CH_W  = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  capCtrl_t        strb,
  input  logic [AW-1:0]   slot,
  input  logic [CH_W-1:0] chanIn,
  input  logic [AW-1:0]   rdAddr,
  output logic [CH_W-1:0] rdData
);

  logic [CH_W-1:0] sampleLatch;
  logic [AW-1:0]   wrSlot;
  logic            wrPend;
  logic [CH_W-1:0] memArr [DEPTH];

  // all channels caught together, written one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampleLatch <= '0;
      wrSlot      <= '0;
      wrPend      <= 1'b0;
    end else begin
      wrPend <= strb.latchEn;
      if (strb.latchEn) begin
        sampleLatch <= chanIn;
        wrSlot      <= slot;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wrPend) memArr[wrSlot] <= sampleLatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rdData <= '0;
    else if (strb.readEn) rdData <= memArr[rdAddr];
  end

  // R9: readout frozen while a run is active
  assert_read_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.readEn |=> $stable(rdData));

  // R4: a write always follows a latch by one cycle
  assert_write_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.latchEn |=> wrPend);

endmodule

// File: rtl/la_capture.sv
module la_capture
  import la_cap_pkg::*;
#(
  parameter int CH_W  = 8,
  parameter int DEPTH = 16,
  parameter int DIV_W = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_W-1:0]  chanIn,
  input  logic             sysClkIn,
  input  logic             modeTiming,
  input  logic [DIV_W-1:0] divN,
  input  logic             armReq,
  input  logic             abortReq,
  input  logic [AW-1:0]    rdAddr,
  output logic [CH_W-1:0]  rdData,
  output logic [CNT_W-1:0] sampleCount,
  output logic             armed,
  output logic             capturing,
  output logic             done
);

  capCtrl_t      strb;
  logic [AW-1:0] slot;
  logic          runActive;
  logic          sampleTick;

  la_cap_strobe #(.DIV_W(DIV_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .sysClkIn(sysClkIn), .modeTiming(modeTiming),
    .divN(divN), .runActive(runActive), .restart(armReq), .sampleTick(sampleTick)
  );

  la_cap_ctrl #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .armReq(armReq), .abortReq(abortReq),
    .sampleTick(sampleTick), .strb(strb), .slot(slot), .sampleCount(sampleCount),
    .runActive(runActive), .armed(armed), .capturing(capturing), .done(done)
  );

  la_cap_path #(.CH_W(CH_W), .DEPTH(DEPTH), .AW(AW)) u_path (
    .clk(clk), .rst_n(rst_n), .strb(strb), .slot(slot), .chanIn(chanIn),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  // R8: status flags are mutually exclusive
  assert_status_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({armed, capturing, done}));

endmodule

// File: tb/la_capture_tb.sv
module la_capture_tb;

  localparam int CH_W  = 8;
  localparam int DEPTH = 16;
  localparam int DIV_W = 8;
  localparam int AW    = 4;
  localparam int CNT_W = 5;
  localparam int NDIV  = 4;
  localparam int DIV_TAB [NDIV] = '{0, 1, 2, 4};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CH_W-1:0]  chanIn = '0;
  logic             sysClkIn = 1'b0;
  logic             modeTiming = 1'b0;
  logic [DIV_W-1:0] divN = '0;
  logic             armReq = 1'b0;
  logic             abortReq = 1'b0;
  logic [AW-1:0]    rdAddr = '0;
  logic [CH_W-1:0]  rdData;
  logic [CNT_W-1:0] sampleCount;
  logic             armed, capturing, done;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  la_capture #(.CH_W(CH_W), .DEPTH(DEPTH), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .chanIn(chanIn), .sysClkIn(sysClkIn),
    .modeTiming(modeTiming), .divN(divN), .armReq(armReq), .abortReq(abortReq),
    .rdAddr(rdAddr), .rdData(rdData), .sampleCount(sampleCount),
    .armed(armed), .capturing(capturing), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; result visible at the next negedge
  task automatic readChk(input string tag, input int addr, input int exp);
    rdAddr = AW'(addr);
    @(negedge clk);
    chk(tag, int'(rdData), exp & 8'hFF);
  endtask

  task automatic armRun(input logic tmode, input int n);
    modeTiming = tmode;
    divN       = DIV_W'(n);
    armReq     = 1'b1;
    @(negedge clk);
    armReq     = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int stamp;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 armed", int'(armed), 0);
    chk("R1 capturing", int'(capturing), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 count", int'(sampleCount), 0);
    chk("R1 rdData", int'(rdData), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 state mode: one sample per rising edge of sysClkIn
    armRun(1'b0, 0);
    chk("R8 armed before first sample", int'(armed), 1);
    chk("R8 capturing before first sample", int'(capturing), 0);
    for (int k = 0; k < DEPTH; k++) begin
      chanIn   = CH_W'(k * 7 + 5);
      sysClkIn = 1'b1;
      repeat (5) @(negedge clk);
      sysClkIn = 1'b0;
      repeat (5) @(negedge clk);
      if (k < DEPTH - 1) begin
        chk("R2 count per edge", int'(sampleCount), k + 1);
        if (k == 0) chk("R8 capturing after first", int'(capturing), 1);
      end
    end
    chk("R5 state done", int'(done), 1);
    chk("R5 state count", int'(sampleCount), DEPTH);
    for (int k = 0; k < DEPTH; k++) readChk("R2 R4 state word", k, k * 7 + 5);

    // R3 timing mode vectors: divisor table walked by one loop
    for (int v = 0; v < NDIV; v++) begin
      int j;
      int n;
      n = DIV_TAB[v];
      modeTiming = 1'b1;
      divN = DIV_W'(n);
      armReq = 1'b1;
      @(negedge clk);
      armReq = 1'b0;
      j = 1;
      chanIn = CH_W'(j);
      stamp = -1;
      while (j < 2000) begin
        @(negedge clk);
        if (done) begin
          stamp = j;
          break;
        end
        j++;
        chanIn = CH_W'(j);
      end
      chk("R3 R5 done edge", stamp, DEPTH * (n + 1));
      chk("R5 timing count", int'(sampleCount), DEPTH);
      for (int k = 0; k < DEPTH; k++) readChk("R3 R4 timing word", k, (k + 1) * (n + 1));
    end

    // R5 no sampling after full
    repeat (20) @(negedge clk);
    chk("R5 count holds", int'(sampleCount), DEPTH);
    chk("R5 done holds", int'(done), 1);
    readChk("R5 word 0 kept", 0, 5);

    // R6 abort mid-run, N=1: samples at edges 2,4,...
    armRun(1'b1, 1);
    chk("R7 done cleared by arm", int'(done), 0);
    chk("R7 count cleared by arm", int'(sampleCount), 0);
    for (int j = 1; j <= 10; j++) begin
      chanIn = CH_W'(j);
      @(negedge clk);
    end
    chk("R8 capturing mid-run", int'(capturing), 1);
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    chk("R6 done after abort", int'(done), 1);
    chk("R6 count after abort", int'(sampleCount), 5);
    chk("R8 capturing after abort", int'(capturing), 0);
    for (int k = 0; k < 5; k++) readChk("R6 aborted word", k, (k + 1) * 2);

    // R7 arm wins over simultaneous abort; state mode with no edges
    modeTiming = 1'b0;
    sysClkIn   = 1'b0;
    armReq     = 1'b1;
    abortReq   = 1'b1;
    @(negedge clk);
    armReq     = 1'b0;
    abortReq   = 1'b0;
    chk("R7 armed priority", int'(armed), 1);
    chk("R7 done priority", int'(done), 0);
    chk("R7 count priority", int'(sampleCount), 0);

    // R9 readout frozen while armed (last read was address 4 = 10)
    rdAddr = AW'(1);
    repeat (3) @(negedge clk);
    chk("R9 frozen addr1", int'(rdData), 10);
    rdAddr = AW'(3);
    @(negedge clk);
    chk("R9 frozen addr3", int'(rdData), 10);

    // R6 abort before any sample
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    chk("R6 empty abort done", int'(done), 1);
    chk("R6 empty abort count", int'(sampleCount), 0);
    readChk("R9 read after run", 2, 6);

    summary();
  end

endmodule